// File: doc/BRIEF.md
# Open-Drain Multiplexed Address/Data Port

This block models one byte-wide microcontroller port whose pins serve two purposes. In general I/O mode every bit has an output latch, and the only pad driver is a pull-down. A latched 0 pulls the pin low. A latched 1 releases the pin, so it reads high only when an external pull-up or device makes it high. Because there is no internal pull-up, software must set a bit's latch to 1 before it can use that bit as an input. Otherwise the pull-down holds the pin at 0 whatever the outside world does.

When the bus-mode control input is high, the latch no longer reaches the pad. Each pin instead carries one bit of the low address/data byte and is driven actively in both directions, so no pull-up is needed. The CPU side can do whole-byte writes and single-bit set or clear writes to the latch. It can read back either the sampled pin levels or the latch contents, each on its own strobe. Read-modify-write sequences use the latch path, so a pin held low from outside cannot corrupt the latch.

The pad is modelled as two enable vectors, one for driving low and one for driving high, plus a sampled pin level. All outputs are registered.

Top module: `odmux_port`

## Requirements
- R1: While `rst` is high at a clock edge, every latch bit becomes 1, both drive enables become all-zero, and `rdata_o` and `rvalid_o` become 0.
- R2: A byte write (`wr_byte_i` high) loads all eight latch bits from `wdata_i` at that clock edge.
- R3: A bit write (`wr_bit_i` high) sets latch bit `bit_idx_i` (0 is the least significant bit) to `bit_val_i` and leaves the other bits unchanged. If a byte write happens in the same cycle, the indexed bit takes `bit_val_i` and the remaining bits take `wdata_i`.
- R4: In I/O mode (`bus_mode_i` low), `drv_lo_o[i]` equals the inverse of latch bit i one clock after the latch holds that value, and `drv_hi_o` is all-zero. A bit whose latch is 0 therefore reads 0 on the pin path even when the outside level is high.
- R5: In bus mode (`bus_mode_i` high), one clock after the control and `ad_out_i` are sampled, `drv_hi_o` equals `ad_out_i` and `drv_lo_o` equals its inverse. The latch keeps its value unless it is written.
- R6: A read-pin strobe returns the `pin_in_i` value sampled at that edge on `rdata_o`, with `rvalid_o` high, in the following cycle.
- R7: A read-latch strobe returns the latch contents from before any write in the same edge, with `rvalid_o` high, in the following cycle. If both strobes are high, the latch contents are returned.
- R8: No bit ever has `drv_hi_o` and `drv_lo_o` set at the same time.
- R9: In a cycle after an edge with no read strobe, `rdata_o` is all-zero and `rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_byte_i | input | 1 | Byte write strobe for the latch |
| wdata_i | input | 8 | Byte write data |
| wr_bit_i | input | 1 | Single-bit write strobe |
| bit_idx_i | input | 3 | Index of the bit for a single-bit write |
| bit_val_i | input | 1 | Value for a single-bit write |
| rd_pin_i | input | 1 | Read strobe for the pin levels |
| rd_latch_i | input | 1 | Read strobe for the latch contents |
| bus_mode_i | input | 1 | 1 selects address/data bus mode, 0 selects I/O mode |
| ad_out_i | input | 8 | Address/data byte to drive in bus mode |
| pin_in_i | input | 8 | Sampled pin levels |
| drv_lo_o | output | 8 | Per-bit pull-down enable |
| drv_hi_o | output | 8 | Per-bit active drive-high enable |
| rdata_o | output | 8 | Read data returned to the CPU |
| rvalid_o | output | 1 | Read data valid |

## Verification
The assertions assume that reset is held for at least one edge before any checked activity. They also assume that every strobe and control input is a known 0 or 1 at each rising edge. The bench meets both conditions by starting with reset high, driving every input to a defined value at time zero, and changing inputs only on falling edges. It feeds `pin_in_i` from a model of the pad: the high driver wins, otherwise the pull-down, otherwise the external level, where a released line with nothing outside reads as the pull-up 1. This lets the pin-read checks catch a latch 0 masking an external 1, and bus mode overriding a low external level.

// File: rtl/odmux_pkg.sv
package odmux_pkg;

  // Source selected for the CPU read bus in a given cycle.
  typedef enum logic [1:0] {
    RSEL_NONE  = 2'd0,
    RSEL_PIN   = 2'd1,
    RSEL_LATCH = 2'd2
  } rsel_e;

  // Latch reset value: every pin released and ready as input.
  function automatic logic [63:0] latch_reset_word();
    return '1;
  endfunction

endpackage

// File: rtl/odmux_latch.sv
module odmux_latch #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_byte,
  input  logic [W-1:0]     wdata,
  input  logic             wr_bit,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_val,
  output logic [W-1:0]     latch_q
);
  import odmux_pkg::*;

  localparam logic [W-1:0] RST_VAL = W'(latch_reset_word());

  // One flop per bit; a bit write aimed at this bit overrides a byte write.
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic hit;
    assign hit = wr_bit && (bit_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst)          latch_q[i] <= RST_VAL[i];
      else if (hit)     latch_q[i] <= bit_val;
      else if (wr_byte) latch_q[i] <= wdata[i];
    end
  end

  // Bit write touches only the indexed bit.
  AST_BIT_WRITE_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (wr_bit && !wr_byte) |=> (latch_q[$past(bit_idx)] == $past(bit_val)) &&
      ((latch_q ^ $past(latch_q)) & ~(W'(1) << $past(bit_idx))) == '0); // R3

  // Byte write alone loads the whole byte.
  AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_byte && !wr_bit) |=> latch_q == $past(wdata)); // R2

  // Without any write the latch holds.
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!wr_byte && !wr_bit) |=> $stable(latch_q)); // R5

endmodule

// File: rtl/odmux_pad_drive.sv
module odmux_pad_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_mode,
  input  logic [W-1:0] ad_out,
  input  logic [W-1:0] latch_q,
  output logic [W-1:0] drv_lo,
  output logic [W-1:0] drv_hi
);

  // Per bit: the mux picks the pull-down source, the AND gate opens the high
  // driver only in bus mode.
  for (genvar i = 0; i < W; i++) begin : g_pad
    logic lo_nxt, hi_nxt;
    always_comb begin
      lo_nxt = bus_mode ? ~ad_out[i] : ~latch_q[i];
      hi_nxt = bus_mode & ad_out[i];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        drv_lo[i] <= 1'b0;
        drv_hi[i] <= 1'b0;
      end else begin
        drv_lo[i] <= lo_nxt;
        drv_hi[i] <= hi_nxt;
      end
    end
  end

  AST_NO_CONTENTION: assert property (@(posedge clk)
    (drv_hi & drv_lo) == '0); // R8

  AST_IO_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
    !bus_mode |=> drv_hi == '0); // R4

  AST_BUS_FOLLOWS_AD: assert property (@(posedge clk) disable iff (rst)
    bus_mode |=> (drv_hi == $past(ad_out)) && (drv_lo == ~$past(ad_out))); // R5

endmodule

// File: rtl/odmux_read_path.sv
module odmux_read_path #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_pin,
  input  logic         rd_latch,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] latch_q,
  output logic [W-1:0] rdata,
  output logic         rvalid
);
  import odmux_pkg::*;

  rsel_e sel;

  // Latch path has priority so read-modify-write never sees the pin.
  always_comb begin
    if (rd_latch)    sel = RSEL_LATCH;
    else if (rd_pin) sel = RSEL_PIN;
    else             sel = RSEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      unique case (sel)
        RSEL_LATCH: rdata <= latch_q;
        RSEL_PIN:   rdata <= pin_in;
        default:    rdata <= '0;
      endcase
      rvalid <= (sel != RSEL_NONE);
    end
  end

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    (!rd_pin && !rd_latch) |=> (rdata == '0) && !rvalid); // R9

  AST_LATCH_READ: assert property (@(posedge clk) disable iff (rst)
    rd_latch |=> rvalid && (rdata == $past(latch_q))); // R7

  AST_PIN_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_pin && !rd_latch) |=> rvalid && (rdata == $past(pin_in))); // R6

endmodule

// File: rtl/odmux_port.sv
module odmux_port #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_byte_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             wr_bit_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             bit_val_i,
  input  logic             rd_pin_i,
  input  logic             rd_latch_i,
  input  logic             bus_mode_i,
  input  logic [W-1:0]     ad_out_i,
  input  logic [W-1:0]     pin_in_i,
  output logic [W-1:0]     drv_lo_o,
  output logic [W-1:0]     drv_hi_o,
  output logic [W-1:0]     rdata_o,
  output logic             rvalid_o
);

  logic [W-1:0] latch_q;

  odmux_latch #(.W(W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .wr_byte (wr_byte_i),
    .wdata   (wdata_i),
    .wr_bit  (wr_bit_i),
    .bit_idx (bit_idx_i),
    .bit_val (bit_val_i),
    .latch_q (latch_q)
  );

  odmux_pad_drive #(.W(W)) u_pad (
    .clk      (clk),
    .rst      (rst),
    .bus_mode (bus_mode_i),
    .ad_out   (ad_out_i),
    .latch_q  (latch_q),
    .drv_lo   (drv_lo_o),
    .drv_hi   (drv_hi_o)
  );

  odmux_read_path #(.W(W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_pin   (rd_pin_i),
    .rd_latch (rd_latch_i),
    .pin_in   (pin_in_i),
    .latch_q  (latch_q),
    .rdata    (rdata_o),
    .rvalid   (rvalid_o)
  );

  // Reset releases every pad and parks the latch at all ones.
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (latch_q == '1) && (drv_lo_o == '0) && (drv_hi_o == '0) && !rvalid_o); // R1

endmodule

// File: tb/test_odmux_port.sv
`timescale 1ns/1ps
module test_odmux_port;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_byte = 1'b0, wr_bit = 1'b0, bit_val = 1'b0;
  logic [7:0] wdata = '0, ad_out = '0, ext_lvl = 8'hFF;
  logic [2:0] bit_idx = '0;
  logic       rd_pin = 1'b0, rd_latch = 1'b0, bus_mode = 1'b0;
  logic [7:0] pin_in, drv_lo, drv_hi, rdata;
  logic       rvalid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // Pad model: high driver, else pull-down, else external level (pull-up = 1).
  assign pin_in = drv_hi | (~drv_lo & ext_lvl);

  odmux_port i_odmux_port (
    .clk(clk), .rst(rst), .wr_byte_i(wr_byte), .wdata_i(wdata),
    .wr_bit_i(wr_bit), .bit_idx_i(bit_idx), .bit_val_i(bit_val),
    .rd_pin_i(rd_pin), .rd_latch_i(rd_latch), .bus_mode_i(bus_mode),
    .ad_out_i(ad_out), .pin_in_i(pin_in), .drv_lo_o(drv_lo),
    .drv_hi_o(drv_hi), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  // {byte written, external level, expected pin read}
  localparam logic [23:0] VEC [8] = '{
    24'hFF_FF_FF, 24'h00_FF_00, 24'hA5_FF_A5, 24'hFF_3C_3C,
    24'hF0_0F_00, 24'h5A_F3_52, 24'hC3_99_81, 24'h7E_FF_7E
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_byte(logic [7:0] d);
    wr_byte = 1'b1; wdata = d; step(); wr_byte = 1'b0;
  endtask

  task automatic write_bit(logic [2:0] idx, logic v);
    wr_bit = 1'b1; bit_idx = idx; bit_val = v; step(); wr_bit = 1'b0;
  endtask

  task automatic read_latch(output logic [7:0] d);
    rd_latch = 1'b1; step(); rd_latch = 1'b0; d = rdata;
    chk("R7 rvalid", {15'd0, rvalid}, 16'd1);
  endtask

  task automatic read_pin(output logic [7:0] d);
    rd_pin = 1'b1; step(); rd_pin = 1'b0; d = rdata;
    chk("R6 rvalid", {15'd0, rvalid}, 16'd1);
  endtask

  // R8: contention watch on every cycle out of reset.
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if ((drv_hi & drv_lo) != 8'h00) begin
        errors++;
        $display("FAIL R8 actual=%h expected=00", drv_hi & drv_lo);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    step(); step(); step();
    // R1: reset state
    chk("R1 drv_lo", {8'd0, drv_lo}, 16'h0000);
    chk("R1 drv_hi", {8'd0, drv_hi}, 16'h0000);
    chk("R1 rdata/rvalid", {7'd0, rvalid, rdata}, 16'h0000);
    rst = 1'b0;
    step();
    read_latch(r); chk("R1 latch ones", {8'd0, r}, 16'h00FF);
    step();
    // R9: idle read bus
    chk("R9 idle", {7'd0, rvalid, rdata}, 16'h0000);

    // Vector walk: byte write, drive check, latch and pin readback.
    for (int k = 0; k < 8; k++) begin
      logic [7:0] d, e, p;
      {d, e, p} = VEC[k];
      ext_lvl = e;
      write_byte(d);
      step();
      chk("R4 drv_lo", {8'd0, drv_lo}, {8'd0, ~d});
      chk("R4 drv_hi", {8'd0, drv_hi}, 16'h0000);
      read_latch(r); chk("R2 latch", {8'd0, r}, {8'd0, d});
      read_pin(r);   chk("R6 pin", {8'd0, r}, {8'd0, p});
    end
    ext_lvl = 8'hFF;

    // R3: bit set and clear
    write_byte(8'h00);
    write_bit(3'd5, 1'b1);
    read_latch(r); chk("R3 set bit5", {8'd0, r}, 16'h0020);
    write_byte(8'hFF);
    write_bit(3'd0, 1'b0);
    read_latch(r); chk("R3 clear bit0", {8'd0, r}, 16'h00FE);
    write_bit(3'd7, 1'b0);
    read_latch(r); chk("R3 clear bit7", {8'd0, r}, 16'h007E);
    // R3: byte and bit together
    wr_byte = 1'b1; wdata = 8'h0F; wr_bit = 1'b1; bit_idx = 3'd7; bit_val = 1'b1;
    step(); wr_byte = 1'b0; wr_bit = 1'b0;
    read_latch(r); chk("R3 combined", {8'd0, r}, 16'h008F);

    // R7: read-latch in the same edge as a write returns old value
    wr_byte = 1'b1; wdata = 8'h33; rd_latch = 1'b1;
    step(); wr_byte = 1'b0; rd_latch = 1'b0;
    chk("R7 old value", {7'd0, rvalid, rdata}, 16'h018F);
    // R7: both strobes -> latch wins; pin pulled low from outside
    step();
    ext_lvl = 8'h00;
    rd_pin = 1'b1; rd_latch = 1'b1; step(); rd_pin = 1'b0; rd_latch = 1'b0;
    chk("R7 priority", {7'd0, rvalid, rdata}, 16'h0133);
    read_pin(r); chk("R6 loaded pin", {8'd0, r}, 16'h0000);

    // R5: bus mode drives both levels, latch untouched
    bus_mode = 1'b1; ad_out = 8'h96;
    step();
    chk("R5 drv_hi", {8'd0, drv_hi}, 16'h0096);
    chk("R5 drv_lo", {8'd0, drv_lo}, 16'h0069);
    read_pin(r);   chk("R5 pin", {8'd0, r}, 16'h0096);
    ad_out = 8'h3C;
    step();
    chk("R5 follow", {drv_hi, drv_lo}, 16'h3CC3);
    read_latch(r); chk("R5 latch kept", {8'd0, r}, 16'h0033);
    bus_mode = 1'b0; ext_lvl = 8'hFF;
    step();
    chk("R4 back to io", {drv_hi, drv_lo}, 16'h00CC);
    step();
    chk("R9 idle end", {7'd0, rvalid, rdata}, 16'h0000);

    // R1: reset mid-run
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 re-reset", {drv_hi, drv_lo}, 16'h0000);
    read_latch(r); chk("R1 latch after", {8'd0, r}, 16'h00FF);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule